// File: doc/BRIEF.md
# Transparent Serial Transmit Engine

This block sends raw bit streams with no framing, no flags and no CRC. Software describes each outgoing buffer in a small ring of descriptors. Each descriptor holds a byte start address, a byte length, a ready flag, a last flag and an interrupt flag. The engine polls the ring at the current index on its transmit clock. It pulls the buffer from memory as aligned 16-bit words into a three-entry FIFO and raises a request-to-send line. When the physical layer grants the line, it shifts the bytes out most significant bit first, one bit for each transmit clock enable.

Between frames, and whenever no data is loaded, the line carries ones. A chain of buffers with the last flag clear on all but the final one goes out with no gap. If the chain breaks before a buffer flagged as last, the engine reports an underrun. When the final bit of a buffer has been sent, the engine pulses a completion strobe with that buffer's descriptor index, so the ready flag can be cleared. If the buffer's interrupt flag is set, the completion also sets a sticky event bit that can be masked.

Top module: `tts_top`

## Requirements
- R1: `txd` is 1 whenever no buffer bit is being shifted: in reset, while idle, while `rts` waits for a grant, during the optional preamble and after a frame ends.
- R2: When a buffer whose last flag is clear has sent its final bit and no next word is in the FIFO, `underrun` pulses for one cycle, `rts` falls and `txd` returns to 1.
- R3: When a buffer whose last flag is set has sent its final bit, the frame ends with no `underrun` pulse, `rts` falls and `txd` carries ones.
- R4: Memory reads use even byte addresses (`memAddr[0]` is 0) and return a word whose even-address byte sits in bits 15:8. A buffer of length L≥1 starting at byte S takes floor((S+L-1)/2) - floor(S/2) + 1 reads. The byte before an odd S and the byte after an even final address are discarded and never sent.
- R5: A descriptor is sampled only in a cycle with `txClkEn` high and `txEnable` high, so no memory read happens while `txClkEn` stays low.
- R6: `rts` rises only when the FIFO holds three words, or when the whole frame (through the buffer flagged last) has been fetched and is shorter than three words.
- R7: With `rts` high, the first `txClkEn` cycle with `ctsGo` high starts the frame. With `prefixFf`=0 the first data bit appears after that edge. With `prefixFf`=1 eight ones go out first.
- R8: `txEvent` sets when a buffer with its interrupt flag set finishes its last bit, stays set until `evtClr`, and `irq` equals `txEvent & txMask`.
- R9: Buffer bytes are sent in address order, each byte MSB first, one bit for each `txClkEn` cycle, with no gaps between chained buffers.
- R10: After a buffer's last bit, `descDone` pulses once with that buffer's index on `descDoneIdx`. The ring index then advances and wraps from NDESC-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Allows descriptor polling |
| txClkEn | input | 1 | One-cycle transmit clock enable, one per bit |
| ctsGo | input | 1 | Physical-layer grant to start sending |
| prefixFf | input | 1 | Send one all-ones byte before the data |
| txMask | input | 1 | Interrupt mask for the transmit event |
| evtClr | input | 1 | Clears the transmit event bit |
| descIdx | output | $clog2(NDESC) | Ring index being polled |
| descAddr | input | ADDRW | Byte start address of the indexed descriptor |
| descLen | input | LENW | Byte length of the indexed descriptor (at least 1) |
| descReady | input | 1 | Ready flag of the indexed descriptor |
| descLast | input | 1 | Last flag of the indexed descriptor |
| descIntr | input | 1 | Interrupt flag of the indexed descriptor |
| descDone | output | 1 | Buffer completed; clear its ready flag |
| descDoneIdx | output | $clog2(NDESC) | Index of the completed buffer |
| memRd | output | 1 | Word read request, data valid the next cycle |
| memAddr | output | ADDRW | Even byte address of the read |
| memRdata | input | 16 | Read data, even-address byte in bits 15:8 |
| txd | output | 1 | Serial data out |
| rts | output | 1 | Request to send |
| underrun | output | 1 | One-cycle underrun pulse |
| txEvent | output | 1 | Sticky transmit-done event |
| irq | output | 1 | Masked event |

## Verification
The bench drives a buffer starting at an odd address with an even final address. A design that misjudged either edge byte would insert a stray byte into the compared bit stream or read the wrong number of words. It breaks a chain after a buffer whose last flag is clear, where a design that treated the end as clean would miss the underrun pulse. It also fetches a two-word frame that can never fill the FIFO, which a design holding `rts` until the FIFO is full would hang on. The bench stops the transmit clock with a descriptor ready to catch polling outside clock enables, and it chains across the end of the ring to catch a wrong wrap or a completion index reported one buffer late.

// File: rtl/tts_pkg.sv
package tts_pkg;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic descLoad;
    logic issueRd;
    logic idxNext;
    logic serLoad;
    logic serShift;
    logic done;
    logic underrun;
  } tts_strobe_t;

  // datapath state seen by control
  typedef struct packed {
    logic fifoFull;
    logic fifoEmpty;
    logic rdPending;
    logic lastWord;
    logic descLast;
    logic bitsOne;
    logic curEnd;
    logic curLast;
  } tts_status_t;

endpackage

// File: rtl/tts_dpath.sv
module tts_dpath import tts_pkg::*; #(
  parameter int ADDRW = 16,
  parameter int LENW  = 16,
  parameter int NDESC = 4,
  parameter int DEPTH = 3,
  localparam int IDXW = $clog2(NDESC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  tts_strobe_t      stb,
  input  logic             evtClr,
  input  logic [ADDRW-1:0] descAddr,
  input  logic [LENW-1:0]  descLen,
  input  logic             descLast,
  input  logic             descIntr,
  input  logic [15:0]      memRdata,
  output tts_status_t      st,
  output logic [ADDRW-1:0] memAddr,
  output logic [IDXW-1:0]  descIdx,
  output logic             shMsb,
  output logic             doneQ,
  output logic [IDXW-1:0]  doneIdxQ,
  output logic             underQ,
  output logic             txEvent
);
  localparam int WW = ADDRW - 1;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int XW = 5 + IDXW;          // meta: idx,intr,last,end,lo,hi
  localparam int MW = 16 + XW;

  // descriptor walker
  logic [WW-1:0]    wAddr, wLeft;
  logic             firstW, oddStart, evenEnd, dLast, dIntr;
  logic [IDXW-1:0]  dIdx, idxQ;
  logic [ADDRW-1:0] lastByte;

  assign lastByte = descAddr + ADDRW'(descLen) - ADDRW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wAddr <= '0; wLeft <= '0; firstW <= 1'b0; oddStart <= 1'b0;
      evenEnd <= 1'b0; dLast <= 1'b0; dIntr <= 1'b0; dIdx <= '0; idxQ <= '0;
    end else begin
      if (stb.descLoad) begin
        wAddr    <= descAddr[ADDRW-1:1];
        wLeft    <= lastByte[ADDRW-1:1] - descAddr[ADDRW-1:1] + WW'(1);
        firstW   <= 1'b1;
        oddStart <= descAddr[0];
        evenEnd  <= ~lastByte[0];
        dLast    <= descLast;
        dIntr    <= descIntr;
        dIdx     <= idxQ;
      end else if (stb.issueRd) begin
        wAddr  <= wAddr + WW'(1);
        wLeft  <= wLeft - WW'(1);
        firstW <= 1'b0;
      end
      if (stb.idxNext)
        idxQ <= (idxQ == IDXW'(NDESC - 1)) ? '0 : idxQ + IDXW'(1);
    end
  end

  assign memAddr = {wAddr, 1'b0};
  assign descIdx = idxQ;

  // read issue and word FIFO
  logic          rdPending;
  logic [XW-1:0] pendMeta, issueMeta;
  logic          isEnd;
  logic [MW-1:0] fMem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic [MW-1:0] head;

  assign isEnd     = (wLeft == WW'(1));
  assign issueMeta = {dIdx, dIntr, dLast, isEnd, ~(isEnd & evenEnd), ~(firstW & oddStart)};
  assign head      = fMem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPending <= 1'b0; pendMeta <= '0; wrPtr <= '0; rdPtr <= '0; count <= '0;
    end else begin
      rdPending <= stb.issueRd;
      if (stb.issueRd) pendMeta <= issueMeta;
      if (rdPending) wrPtr <= nextPtr(wrPtr);
      if (stb.serLoad) rdPtr <= nextPtr(rdPtr);
      if (rdPending && !stb.serLoad)      count <= count + CW'(1);
      else if (!rdPending && stb.serLoad) count <= count - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rdPending) fMem[wrPtr] <= {pendMeta, memRdata};
  end

  // shifter
  logic [15:0]     shReg;
  logic [4:0]      bitsLeft;
  logic            curEnd, curLast, curIntr;
  logic [IDXW-1:0] curIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '1; bitsLeft <= '0; curEnd <= 1'b0; curLast <= 1'b0;
      curIntr <= 1'b0; curIdx <= '0;
    end else if (stb.serLoad) begin
      if (!head[16])      begin shReg <= {head[7:0], 8'h00}; bitsLeft <= 5'd8;  end
      else if (!head[17]) begin shReg <= head[15:0];         bitsLeft <= 5'd8;  end
      else                begin shReg <= head[15:0];         bitsLeft <= 5'd16; end
      curEnd  <= head[18];
      curLast <= head[19];
      curIntr <= head[20];
      curIdx  <= head[21 +: IDXW];
    end else if (stb.serShift) begin
      shReg    <= {shReg[14:0], 1'b1};
      bitsLeft <= bitsLeft - 5'd1;
    end
  end

  assign shMsb = shReg[15];

  // completion, underrun and event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0; doneIdxQ <= '0; underQ <= 1'b0; txEvent <= 1'b0;
    end else begin
      doneQ    <= stb.done;
      doneIdxQ <= curIdx;
      underQ   <= stb.underrun;
      if (stb.done && curIntr) txEvent <= 1'b1;
      else if (evtClr)         txEvent <= 1'b0;
    end
  end

  assign st.fifoFull  = (count == CW'(DEPTH));
  assign st.fifoEmpty = (count == '0);
  assign st.rdPending = rdPending;
  assign st.lastWord  = isEnd;
  assign st.descLast  = dLast;
  assign st.bitsOne   = (bitsLeft <= 5'd1);
  assign st.curEnd    = curEnd;
  assign st.curLast   = curLast;

  assert_fifo_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdPending |-> (count < CW'(DEPTH)) || stb.serLoad);
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.serLoad |-> count != '0);
  assert_shift_has_bits_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.serShift |-> bitsLeft > 5'd1);
  assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && curIntr) |=> txEvent);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
endmodule

// File: rtl/tts_ctrl.sv
module tts_ctrl import tts_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEnable,
  input  logic        txClkEn,
  input  logic        ctsGo,
  input  logic        prefixFf,
  input  logic        descReady,
  input  tts_status_t st,
  output tts_strobe_t stb,
  output logic        running,
  output logic        rts
);
  typedef enum logic [1:0] {F_POLL, F_FETCH, F_HOLD} fetch_e;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_PRE, S_RUN} ser_e;

  fetch_e     fState, fNext;
  ser_e       sState, sNext;
  logic [3:0] preCnt;
  logic       frameFetched;

  assign frameFetched = (fState == F_HOLD) && !st.rdPending;

  always_comb begin
    stb    = '0;
    fNext  = fState;
    sNext  = sState;
    unique case (fState)
      F_POLL:
        if (txEnable && txClkEn && descReady) begin
          stb.descLoad = 1'b1;
          fNext = F_FETCH;
        end
      F_FETCH:
        if (!st.rdPending && !st.fifoFull) begin
          stb.issueRd = 1'b1;
          if (st.lastWord) begin
            stb.idxNext = 1'b1;
            fNext = st.descLast ? F_HOLD : F_POLL;
          end
        end
      default:
        if (sState == S_IDLE && st.fifoEmpty && !st.rdPending) fNext = F_POLL;
    endcase
    unique case (sState)
      S_IDLE:
        if (st.fifoFull || (frameFetched && !st.fifoEmpty)) sNext = S_WAIT;
      S_WAIT:
        if (txClkEn && ctsGo) begin
          if (prefixFf) sNext = S_PRE;
          else begin stb.serLoad = 1'b1; sNext = S_RUN; end
        end
      S_PRE:
        if (txClkEn && preCnt == 4'd1) begin
          stb.serLoad = 1'b1;
          sNext = S_RUN;
        end
      default:
        if (txClkEn) begin
          if (!st.bitsOne) stb.serShift = 1'b1;
          else begin
            stb.done = st.curEnd;
            if (!st.fifoEmpty) stb.serLoad = 1'b1;
            else begin
              sNext = S_IDLE;
              stb.underrun = !(st.curEnd && st.curLast);
            end
          end
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fState <= F_POLL;
      sState <= S_IDLE;
      preCnt <= '0;
    end else begin
      fState <= fNext;
      sState <= sNext;
      if (sState == S_WAIT && sNext == S_PRE) preCnt <= 4'd8;
      else if (sState == S_PRE && txClkEn)    preCnt <= preCnt - 4'd1;
    end
  end

  assign running = (sState == S_RUN);
  assign rts     = (sState != S_IDLE);

  assert_poll_on_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.descLoad |-> txClkEn && txEnable);
  assert_underrun_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.underrun |-> st.fifoEmpty && !(st.curEnd && st.curLast));
  assert_rts_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sState == S_WAIT && $past(sState) == S_IDLE) |->
      $past(st.fifoFull || (fState == F_HOLD && !st.rdPending)));
  assert_issue_room_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueRd |-> !st.fifoFull && !st.rdPending);
endmodule

// File: rtl/tts_top.sv
module tts_top import tts_pkg::*; #(
  parameter int ADDRW = 16,
  parameter int LENW  = 16,
  parameter int NDESC = 4,
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     txEnable,
  input  logic                     txClkEn,
  input  logic                     ctsGo,
  input  logic                     prefixFf,
  input  logic                     txMask,
  input  logic                     evtClr,
  output logic [$clog2(NDESC)-1:0] descIdx,
  input  logic [ADDRW-1:0]         descAddr,
  input  logic [LENW-1:0]          descLen,
  input  logic                     descReady,
  input  logic                     descLast,
  input  logic                     descIntr,
  output logic                     descDone,
  output logic [$clog2(NDESC)-1:0] descDoneIdx,
  output logic                     memRd,
  output logic [ADDRW-1:0]         memAddr,
  input  logic [15:0]              memRdata,
  output logic                     txd,
  output logic                     rts,
  output logic                     underrun,
  output logic                     txEvent,
  output logic                     irq
);
  tts_strobe_t stb;
  tts_status_t st;
  logic        running, shMsb;

  tts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txClkEn(txClkEn),
    .ctsGo(ctsGo), .prefixFf(prefixFf), .descReady(descReady),
    .st(st), .stb(stb), .running(running), .rts(rts)
  );

  tts_dpath #(.ADDRW(ADDRW), .LENW(LENW), .NDESC(NDESC), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .evtClr(evtClr),
    .descAddr(descAddr), .descLen(descLen), .descLast(descLast), .descIntr(descIntr),
    .memRdata(memRdata), .st(st), .memAddr(memAddr), .descIdx(descIdx),
    .shMsb(shMsb), .doneQ(descDone), .doneIdxQ(descDoneIdx),
    .underQ(underrun), .txEvent(txEvent)
  );

  assign memRd = stb.issueRd;
  assign txd   = running ? shMsb : 1'b1;
  assign irq   = txEvent & txMask;
endmodule

// File: tb/tts_top_tb.sv
`timescale 1ns/1ps
module tts_top_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rstN = 1'b0, txEnable = 1'b0, txClkEn = 1'b0, ctsGo = 1'b0;
  logic        prefixFf = 1'b0, txMask = 1'b0, evtClr = 1'b0;
  logic [1:0]  descIdx, descDoneIdx;
  logic [15:0] descAddr, descLen, memAddr, memRdata;
  logic        descReady, descLast, descIntr, descDone, memRd;
  logic        txd, rts, underrun, txEvent, irq;

  logic [15:0] dAddr [4];
  logic [15:0] dLen  [4];
  logic        dRdy  [4];
  logic        dLst  [4];
  logic        dInt  [4];

  assign descAddr  = dAddr[descIdx];
  assign descLen   = dLen[descIdx];
  assign descReady = dRdy[descIdx];
  assign descLast  = dLst[descIdx];
  assign descIntr  = dInt[descIdx];

  tts_top u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .txClkEn(txClkEn), .ctsGo(ctsGo),
    .prefixFf(prefixFf), .txMask(txMask), .evtClr(evtClr), .descIdx(descIdx),
    .descAddr(descAddr), .descLen(descLen), .descReady(descReady), .descLast(descLast),
    .descIntr(descIntr), .descDone(descDone), .descDoneIdx(descDoneIdx), .memRd(memRd),
    .memAddr(memAddr), .memRdata(memRdata), .txd(txd), .rts(rts), .underrun(underrun),
    .txEvent(txEvent), .irq(irq)
  );

  int errors = 0, checks = 0, rdCnt = 0, underCnt = 0, divCnt = 0;
  logic clkRun = 1'b0;
  logic expBits [$];
  int   doneLog [$];

  function automatic logic [7:0] byteAt(input logic [15:0] a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // memory model: one-cycle read latency, big-endian word
  always @(posedge clk) begin
    if (memRd) begin
      rdCnt++;
      memRdata <= {byteAt({memAddr[15:1], 1'b0}), byteAt({memAddr[15:1], 1'b1})};
    end
  end

  // monitor and transmit clock enable generator
  always @(negedge clk) begin
    if (memRd) chk("R4 even read address", int'(memAddr[0]), 0);
    if (txClkEn) begin
      logic e;
      e = (expBits.size() != 0) ? expBits.pop_front() : 1'b1;
      chk("R9/R1 serial bit", int'(txd), int'(e));
    end
    if (underrun) underCnt++;
    if (descDone) begin
      doneLog.push_back(int'(descDoneIdx));
      dRdy[descDoneIdx] = 1'b0;
    end
    divCnt = (divCnt + 1) % 4;
    txClkEn = clkRun && (divCnt == 0);
  end

  task automatic setDesc(input int i, input logic [15:0] a, input logic [15:0] l,
                         input logic lst, input logic intr);
    dAddr[i] = a; dLen[i] = l; dLst[i] = lst; dInt[i] = intr; dRdy[i] = 1'b1;
  endtask

  task automatic pushBytes(input logic [15:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b;
      b = byteAt(a + 16'(k));
      for (int j = 7; j >= 0; j--) expBits.push_back(b[j]);
    end
  endtask

  task automatic waitRts();
    while (!rts) @(negedge clk);
    repeat (9) @(negedge clk);
    chk("R1 ones while waiting for grant", int'(txd), 1);
    #1;
  endtask

  task automatic drain();
    while (expBits.size() != 0 || rts) @(negedge clk);
    #1 ctsGo = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic chkDone(input string req, input int idx);
    if (doneLog.size() == 0) chk(req, -1, idx);
    else chk(req, doneLog.pop_front(), idx);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rd0, u0;
    for (int i = 0; i < 4; i++) begin
      dAddr[i] = '0; dLen[i] = 16'd1; dRdy[i] = 1'b0; dLst[i] = 1'b0; dInt[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset txd", int'(txd), 1);
    chk("R6 reset rts", int'(rts), 0);
    chk("R8 reset irq", int'(irq), 0);
    chk("R2 reset underrun", int'(underrun), 0);

    // R5: stopped transmit clock, descriptor ready, nothing must happen
    #1 txEnable = 1'b1; txMask = 1'b1;
    setDesc(0, 16'h0010, 16'd6, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    chk("R5 no reads without clock enable", rdCnt, 0);
    chk("R5 no rts without clock enable", int'(rts), 0);
    #1 clkRun = 1'b1;
    waitRts();
    chk("R6 rts after three words", rdCnt, 3);
    pushBytes(16'h0010, 6);
    ctsGo = 1'b1;
    drain();
    chk("R3 clean end no underrun", underCnt, 0);
    chkDone("R10 completion index 0", 0);
    chk("R8 event set", int'(txEvent), 1);
    chk("R8 irq unmasked", int'(irq), 1);
    #1 txMask = 1'b0;
    @(negedge clk);
    chk("R8 irq masked", int'(irq), 0);
    #1 evtClr = 1'b1; @(negedge clk); #1 evtClr = 1'b0; txMask = 1'b1;
    @(negedge clk);
    chk("R8 event cleared", int'(txEvent), 0);

    // R4/R7: odd start, even end, preamble of ones
    rd0 = rdCnt;
    prefixFf = 1'b1;
    setDesc(1, 16'h0021, 16'd10, 1'b1, 1'b0);
    waitRts();
    for (int j = 0; j < 8; j++) expBits.push_back(1'b1);
    pushBytes(16'h0021, 10);
    ctsGo = 1'b1;
    drain();
    chk("R4 word reads for odd buffer", rdCnt - rd0, 6);
    chkDone("R10 completion index 1", 1);
    chk("R8 no event without flag", int'(txEvent), 0);
    prefixFf = 1'b0;

    // R2: chain broken after a non-last buffer
    u0 = underCnt;
    setDesc(2, 16'h0040, 16'd7, 1'b0, 1'b1);
    waitRts();
    pushBytes(16'h0040, 7);
    ctsGo = 1'b1;
    drain();
    chk("R2 underrun pulse", underCnt - u0, 1);
    chk("R2 rts low after underrun", int'(rts), 0);
    chkDone("R10 completion index 2", 2);
    chk("R8 event from flagged buffer", int'(txEvent), 1);
    #1 evtClr = 1'b1; @(negedge clk); #1 evtClr = 1'b0;

    // R6/R9/R10: two-word chain across the ring wrap
    rd0 = rdCnt;
    setDesc(3, 16'h0060, 16'd2, 1'b0, 1'b0);
    setDesc(0, 16'h0081, 16'd1, 1'b1, 1'b0);
    waitRts();
    chk("R6 short frame starts with two words", rdCnt - rd0, 2);
    pushBytes(16'h0060, 2);
    pushBytes(16'h0081, 1);
    ctsGo = 1'b1;
    drain();
    chk("R3 chained end no underrun", underCnt - u0, 1);
    chkDone("R10 completion index 3", 3);
    chkDone("R10 wrap to index 0", 0);
    chk("R8 event stays clear", int'(txEvent), 0);
    chk("R1 idle ones at end", int'(txd), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule